// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges three reset sources into the one active-low reset that drives the processor core and the peripherals. The first source is an active-low external pin. The second is a watchdog reset request that software must enable. The third is a key-combination reset. It fires when every port input in a software-chosen subset of four is low at once.

The pin asserts the internal reset at once, with no clock needed. The internal reset is released through a two-stage synchronizer. Every key input passes through its own two-flop synchronizer before the all-low test. When a key or watchdog event occurs, the reset is stretched for a fixed number of clocks.

The configuration register holds the key selection mask and the watchdog enable. The internal reset clears this register, so the two software sources cannot act as a power-on reset. A cause register records which source produced the most recent reset. It keeps its value through a reset caused by the block itself.

Top module: `reset_merge_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst_n` is low, and it goes low in the same instant the pin falls, without waiting for a clock edge.
- R2: After `ext_rst_n` returns high, with no other source active, `sys_rst_n` stays low after the first rising edge and is high after the second.
- R3: Any internal reset clears `cfg_rd` to zero, meaning no key bits are selected and the watchdog is disabled. Once cleared, key and watchdog inputs cause no reset, even if they stay active through the release.
- R4: Bits [3:0] of the configuration word form the key mask, one bit per `key_in` bit. When the mask is nonzero and every selected key is low on the sampled inputs, `sys_rst_n` falls on the third rising edge after the keys change. Unselected keys have no effect.
- R5: When at least one selected key is high, no reset occurs.
- R6: With a mask of zero, no pattern on `key_in` causes a reset, including all keys low.
- R7: Bit 4 of the configuration word is the watchdog enable. With it set, a high `wdt_req` at a rising edge pulls `sys_rst_n` low at that edge. With it clear, `wdt_req` has no effect.
- R8: A key or watchdog reset is held for 16 cycles after its condition ends. `sys_rst_n` is low from the asserting edge through the 17th edge after it, and high after the 18th.
- R9: `rst_cause` is one-hot: 3'b001 for the pin, 3'b010 for a key combination, 3'b100 for the watchdog. It holds its value after `sys_rst_n` is released.
- R10: With `sys_rst_n` high, a write with `cfg_we` high stores `cfg_wdata`, and the stored value appears on `cfg_rd` after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, active low |
| key_in | input | 4 | Port inputs watched for the key combination |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Write data: [4] watchdog enable, [3:0] key mask |
| cfg_rd | output | 5 | Current configuration value |
| wdt_req | input | 1 | Reset request from the watchdog counter |
| rst_cause | output | 3 | One-hot source of the latest reset |
| sys_rst_n | output | 1 | Internal reset, active low |

## Verification
On every cycle, the embedded properties check the following:
- A pin held low keeps the internal reset active.
- A detected key or watchdog event asserts reset on the following edge.
- The stretch counter keeps reset low while it runs.
- Release happens only once both the pin and the counter are idle.
- The configuration is empty whenever reset is active.
- The cause register is never empty.

Other behaviours are visible only in the directed scenarios:
- the exact release edges;
- the three-edge latency through the key synchronizer;
- the 18-cycle length of a stretched reset;
- partial matches and a zero mask causing no reset;
- keys held low through a release not firing again;
- the cause value read after each source.

// File: rtl/reset_merge_ctrl.sv
module reset_merge_ctrl #(
  parameter int KEYS     = 4,
  parameter int HOLD_CYC = 16,
  parameter int KSYNC    = 2,
  parameter int RSYNC    = 2
) (
  input  logic            clk,
  input  logic            ext_rst_n,
  input  logic [KEYS-1:0] key_in,
  input  logic            cfg_we,
  input  logic [KEYS:0]   cfg_wdata,
  output logic [KEYS:0]   cfg_rd,
  input  logic            wdt_req,
  output logic [2:0]      rst_cause,
  output logic            sys_rst_n
);

  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [KSYNC-1:0][KEYS-1:0] ksync;
  logic [KEYS-1:0]            key_mask;
  logic                       wdt_en;
  logic [CW-1:0]              hold_cnt;
  logic [RSYNC-1:0]           rel;
  logic                       key_hit, wdt_hit, trig, soft_rst, raw_rst;

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n) ksync <= '1;
    else            ksync <= {ksync[KSYNC-2:0], key_in};

  assign key_hit  = (key_mask != '0) && ((ksync[KSYNC-1] & key_mask) == '0);
  assign wdt_hit  = wdt_en & wdt_req;
  assign trig     = key_hit | wdt_hit;

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n)         hold_cnt <= '0;
    else if (trig)          hold_cnt <= CW'(HOLD_CYC);
    else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;

  assign soft_rst = (hold_cnt != '0);
  assign raw_rst  = !ext_rst_n || soft_rst;

  always_ff @(posedge clk or posedge raw_rst)
    if (raw_rst) rel <= '0;
    else         rel <= {rel[RSYNC-2:0], 1'b1};

  assign sys_rst_n = rel[RSYNC-1];

  always_ff @(posedge clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      key_mask <= '0;
      wdt_en   <= 1'b0;
    end else if (cfg_we) begin
      key_mask <= cfg_wdata[KEYS-1:0];
      wdt_en   <= cfg_wdata[KEYS];
    end

  assign cfg_rd = {wdt_en, key_mask};

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n) rst_cause <= 3'b001;
    else if (trig)  rst_cause <= {wdt_hit, key_hit, 1'b0};

  AST_PIN_HOLDS: assert property (@(posedge clk)
    !ext_rst_n |=> !sys_rst_n);  // R1
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(sys_rst_n) |-> !soft_rst);  // R2
  AST_CFG_CLEARED: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !sys_rst_n |-> (cfg_rd == '0));  // R3
  AST_EVENT_ASSERTS: assert property (@(posedge clk) disable iff (!ext_rst_n)
    trig |=> !sys_rst_n);  // R4
  AST_HOLD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!ext_rst_n)
    soft_rst |-> !sys_rst_n);  // R8
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!ext_rst_n)
    rst_cause != 3'b000);  // R9

endmodule

// File: tb/reset_merge_ctrl_tb.sv
`timescale 1ns/1ps
module reset_merge_ctrl_tb;
  logic       clk = 0;
  logic       ext_rst_n = 0;
  logic [3:0] key_in = 4'hF;
  logic       cfg_we = 0;
  logic [4:0] cfg_wdata = '0;
  logic       wdt_req = 0;
  logic [4:0] cfg_rd;
  logic [2:0] rst_cause;
  logic       sys_rst_n;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  reset_merge_ctrl u_dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .key_in(key_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .wdt_req(wdt_req),
    .rst_cause(rst_cause), .sys_rst_n(sys_rst_n));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic wen, input logic [3:0] mask);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = {wen, mask};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic t_pin;
    @(negedge clk);
    ext_rst_n = 0;
    #1 check("R1 async assert", sys_rst_n, 0);
    cyc(3);
    check("R1 held low", sys_rst_n, 0);
    ext_rst_n = 1;
    cyc(1);
    check("R2 low after first edge", sys_rst_n, 0);
    cyc(1);
    check("R2 high after second edge", sys_rst_n, 1);
    check("R9 pin cause", rst_cause, 1);
    check("R3 cfg cleared by pin", cfg_rd, 0);
  endtask

  task automatic t_write;
    wr(1'b1, 4'b1001);
    check("R10 write stored", cfg_rd, 5'b11001);
    wr(1'b0, 4'b0000);
    check("R10 rewrite stored", cfg_rd, 0);
  endtask

  task automatic stretch(input string tag);
    check({tag, " R8 low at assert"}, sys_rst_n, 0);
    check({tag, " R3 cfg cleared"}, cfg_rd, 0);
    cyc(17);
    check({tag, " R8 low after 17 edges"}, sys_rst_n, 0);
    cyc(1);
    check({tag, " R8 high after 18 edges"}, sys_rst_n, 1);
  endtask

  task automatic t_key_fire;
    wr(1'b0, 4'b0101);
    key_in = 4'b1010;
    cyc(1);
    check("R4 not yet after edge 1", sys_rst_n, 1);
    cyc(1);
    check("R4 not yet after edge 2", sys_rst_n, 1);
    cyc(1);
    check("R4 asserted after edge 3", sys_rst_n, 0);
    stretch("key");
    check("R9 key cause", rst_cause, 2);
    cyc(6);
    check("R3 held keys do not refire", sys_rst_n, 1);
    key_in = 4'hF;
    cyc(3);
  endtask

  task automatic t_key_partial;
    wr(1'b0, 4'b0011);
    key_in = 4'b1110;
    cyc(6);
    check("R5 partial match no reset", sys_rst_n, 1);
    check("R5 cfg kept", cfg_rd, 5'b00011);
    key_in = 4'hF;
    cyc(3);
  endtask

  task automatic t_mask_zero;
    wr(1'b0, 4'b0000);
    key_in = 4'b0000;
    cyc(6);
    check("R6 zero mask no reset", sys_rst_n, 1);
    key_in = 4'hF;
    cyc(3);
  endtask

  task automatic t_wdt_off;
    wr(1'b0, 4'b0000);
    wdt_req = 1;
    cyc(5);
    check("R7 disabled wdt ignored", sys_rst_n, 1);
    check("R7 cause unchanged", rst_cause, 2);
    wdt_req = 0;
    cyc(1);
  endtask

  task automatic t_wdt_on;
    wr(1'b1, 4'b0000);
    check("R7 enable stored", cfg_rd, 5'b10000);
    wdt_req = 1;
    cyc(1);
    check("R7 wdt asserts", sys_rst_n, 0);
    stretch("wdt");
    check("R9 wdt cause", rst_cause, 4);
    cyc(5);
    check("R3 held wdt_req does not refire", sys_rst_n, 1);
    wdt_req = 0;
    cyc(1);
  endtask

  initial begin
    cyc(1);
    check("R1 low at start", sys_rst_n, 0);
    cyc(3);
    t_pin();
    t_write();
    t_key_fire();
    t_key_partial();
    t_mask_zero();
    t_wdt_off();
    t_wdt_on();
    t_pin();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule